// File: doc/BRIEF.md
# DMA Address Translation Table Walker

This block sits between a PCI-side DMA master and system memory and turns each DMA address into a physical address. Software programs two 64-bit registers over a small register bus: a control word and the physical base of a translation table held in system memory. A third offset acts as a flush register. It takes writes without effect and always reads as zero. Both 32-bit and 64-bit register accesses are supported.

For each DMA request the block does one of three things. When translation is off it passes the address straight through. When the table configuration is invalid it reports a fault at once. Otherwise it builds the address of one 8-byte table entry and fetches it over a read-only memory port. It then turns the entry into a physical address, a page-offset mask and a permission code. Entries are not cached, and only one walk is in flight at a time.

Top module: `dma_xlate_walker`

## Requirements
- R1: Registers are reached through 5-bit byte offsets. The control register sits at 0x00 and the table base at 0x08. A 64-bit access at 0x00 or 0x08 covers the whole register. A 32-bit access at that offset covers bits 63:32, carried in data bits 31:0. Any access at offset +4 (0x04, 0x0C) covers bits 31:0.
- R2: Writes to the flush offsets (0x10, 0x14), to any other offset, or to an offset whose two low bits are not zero leave both registers unchanged. Reads from those offsets return zero.
- R3: While control bit 0 is clear, a request returns its own address, the mask 0x1FFF and the permission code 2'b11 (read/write), and the block does not read memory.
- R4: After reset both registers read zero, req_ready is high, and no response or memory read is pending.
- R5: With control bit 0 set and control bit 2 clear, the table-size code c in control bits 18:16 (0 to 7) selects DMA address bits (22+c):13 as the index. The entry address is base + 8 × index.
- R6: With control bits 0 and 2 set, codes 0 to 5 select DMA address bits (25+c):16 as the index. The entry address is base + 8 × index.
- R7: With control bits 0 and 2 set and code 6 or 7, the request faults without a memory read. A fault returns address 0, an all-ones mask and the permission code 2'b00.
- R8: A fetched entry whose bit 63 is clear gives the fault response of R7.
- R9: A valid entry with bit 1 set gives the permission code 2'b11 (read/write). With bit 1 clear it gives 2'b01 (read-only).
- R10: A valid entry with bit 61 set gives entry bits 40:15 in place, ORed with DMA address bits 15:0, and the mask 0xFFFF. With bit 61 clear it gives entry bits 40:13 in place, ORed with DMA address bits 12:0, and the mask 0x1FFF. All other entry bits are ignored.
- R11: The entry is big-endian. mem_rsp_data bits 8k+7:8k hold the byte at entry address + k, so the byte at the entry address is entry bits 63:56.
- R12: Requests, responses and memory reads use valid/ready handshakes. A response or memory request held without ready stays stable, and req_ready stays low from request acceptance until the response handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe, single cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| reg_rdata | output | 64 | Read data, combinational, same cycle |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_iova | input | 64 | DMA address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 64 | Translated physical address |
| rsp_mask | output | 64 | Page-offset mask of the result |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read/write |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 64 | Table entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Eight entry bytes in address lanes |

## Verification
The bench builds the block with its default parameters: 64-bit addresses and a 5-bit register offset. With these values the full address windows are available, from the smallest 8K window (bits 22:13) to the widest 64K one (bits 30:16). The whole 0x00 to 0x1F offset range is reachable too, so flush and unmapped offsets can be tested next to the live registers. The bench also varies the memory's ready and data latency. This brings the stable-while-stalled handshakes within reach, along with a stalled response that keeps the walker busy.

// File: rtl/xw_pkg.sv
// Shared constants and types for the DMA translation table walker.
// Assumes 64-bit registers and table entries.
package xw_pkg;

    localparam int XW_DW = 64;

    // control register fields
    localparam int CTL_EN     = 0;
    localparam int CTL_PG64   = 2;
    localparam int CTL_TSZ_LO = 16;
    localparam int CTL_TSZ_W  = 3;

    // table entry fields
    localparam int ENT_VALID = 63;
    localparam int ENT_BIG   = 61;
    localparam int ENT_WR    = 1;

    // index windows
    localparam int IDX_MIN_W   = 10;
    localparam int IDX8_LO     = 13;
    localparam int IDX64_LO    = 16;
    localparam int N_CODES_8K  = 8;
    localparam int N_CODES_64K = 6;
    localparam int ENT_BYTES   = 8;

    localparam logic [63:0] PG8_MASK    = 64'h0000_0000_0000_1FFF;
    localparam logic [63:0] PG64_MASK   = 64'h0000_0000_0000_FFFF;
    localparam logic [63:0] PHYS8_SEL   = 64'h0000_01FF_FFFF_E000;
    localparam logic [63:0] PHYS64_SEL  = 64'h0000_01FF_FFFF_8000;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_FETCH,
        W_WAIT,
        W_RESP
    } walk_st_e;

endpackage

// File: rtl/xw_regs.sv
// Register file of the walker: control and table base, 64 bits each.
// Word offset 0 in a slot is the upper half for 32-bit accesses, and
// offset 4 is the lower half. Flush and other offsets read zero.
// Assumes single-cycle accesses with read data used in the same cycle.
module xw_regs #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic              reg_wide,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic [63:0]       ctrl_q,
    output logic [63:0]       base_q
);
    localparam int NREG   = 2;
    localparam int SLOT_W = REG_AW - 3;

    logic [SLOT_W-1:0]         slot;
    logic                      upper_half;
    logic                      aligned;
    logic [NREG-1:0][63:0]     regs_w;

    assign slot       = reg_addr[REG_AW-1:3];
    assign upper_half = ~reg_addr[2];
    assign aligned    = (reg_addr[1:0] == 2'b00);

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            logic        hit;
            logic [63:0] q;
            assign hit = reg_valid && reg_write && aligned && (slot == SLOT_W'(i));
            // update one register from a full, upper or lower write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (hit) begin
                    if (upper_half && reg_wide) begin
                        q <= reg_wdata;
                    end else if (upper_half) begin
                        q[63:32] <= reg_wdata[31:0];
                    end else begin
                        q[31:0] <= reg_wdata[31:0];
                    end
                end
            end
            assign regs_w[i] = q;
        end
    endgenerate

    // read mux: select slot and half, zero for anything unmapped
    always_comb begin
        logic [63:0] sel;
        logic        found;
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (slot == SLOT_W'(i)) begin
                sel   = regs_w[i];
                found = 1'b1;
            end
        end
        reg_rdata = '0;
        if (reg_valid && !reg_write && aligned && found) begin
            if (upper_half) begin
                reg_rdata = reg_wide ? sel : {32'b0, sel[63:32]};
            end else begin
                reg_rdata = {32'b0, sel[31:0]};
            end
        end
    end

    assign ctrl_q = regs_w[0];
    assign base_q = regs_w[1];

endmodule

// File: rtl/xw_index.sv
// Entry address generator. Picks the index window of the DMA address
// from the page mode and table-size code, and adds eight times the
// index to the table base. Flags a size code with no 64K window.
// Purely combinational; assumes ADDR_W of at least 31.
module xw_index #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0]               iova,
    input  logic                            pg64,
    input  logic [xw_pkg::CTL_TSZ_W-1:0]    tsz,
    input  logic [63:0]                     base,
    output logic [63:0]                     ent_addr,
    output logic                            size_bad
);
    import xw_pkg::*;

    logic [N_CODES_8K-1:0][63:0]  off8;
    logic [N_CODES_64K-1:0][63:0] off64;
    logic [63:0]                  off;
    logic                         unused_iova;

    assign unused_iova = ^iova;

    generate
        for (genvar c = 0; c < N_CODES_8K; c++) begin : g_w8
            assign off8[c] = 64'(iova[IDX8_LO +: IDX_MIN_W + c]) << $clog2(ENT_BYTES);
        end
        for (genvar c = 0; c < N_CODES_64K; c++) begin : g_w64
            assign off64[c] = 64'(iova[IDX64_LO +: IDX_MIN_W + c]) << $clog2(ENT_BYTES);
        end
    endgenerate

    // window selection by page mode and size code
    always_comb begin
        off      = '0;
        size_bad = 1'b0;
        if (pg64) begin
            size_bad = (int'(tsz) >= N_CODES_64K);
            for (int c = 0; c < N_CODES_64K; c++) begin
                if (tsz == CTL_TSZ_W'(c)) off = off64[c];
            end
        end else begin
            for (int c = 0; c < N_CODES_8K; c++) begin
                if (tsz == CTL_TSZ_W'(c)) off = off8[c];
            end
        end
    end

    assign ent_addr = base + off;

endmodule

// File: rtl/xw_entry.sv
// Entry decoder. Reorders the big-endian memory lanes into an entry
// and produces the physical address, page mask and permission.
// Combinational; the result is used only while a read returns.
module xw_entry #(
    parameter int ADDR_W = 64
) (
    input  logic [63:0]        lanes,
    input  logic [ADDR_W-1:0]  iova,
    output logic [ADDR_W-1:0]  paddr,
    output logic [ADDR_W-1:0]  mask,
    output xw_pkg::perm_e      perm
);
    import xw_pkg::*;

    logic [63:0] ent;
    logic        unused_ent;

    generate
        for (genvar k = 0; k < ENT_BYTES; k++) begin : g_swap
            assign ent[63-8*k -: 8] = lanes[8*k +: 8];
        end
    endgenerate

    assign unused_ent = ^ent;

    // entry checks and address assembly
    always_comb begin
        paddr = '0;
        mask  = '1;
        perm  = PERM_NONE;
        if (ent[ENT_VALID]) begin
            perm = ent[ENT_WR] ? PERM_RW : PERM_RO;
            if (ent[ENT_BIG]) begin
                mask  = ADDR_W'(PG64_MASK);
                paddr = ADDR_W'(ent & PHYS64_SEL) | (iova & ADDR_W'(PG64_MASK));
            end else begin
                mask  = ADDR_W'(PG8_MASK);
                paddr = ADDR_W'(ent & PHYS8_SEL) | (iova & ADDR_W'(PG8_MASK));
            end
        end
    end

endmodule

// File: rtl/xw_walk.sv
// Walk sequencer. Accepts one request and chooses pass-through, an
// early fault or a table fetch. It drives the memory read, holds the
// decoded result until the consumer takes it, then accepts the next.
module xw_walk #(
    parameter int ADDR_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_iova,
    input  logic               xl_en,
    input  logic               size_bad,
    input  logic [63:0]        ent_addr,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    output logic [ADDR_W-1:0]  iova_q,
    input  logic [ADDR_W-1:0]  dec_paddr,
    input  logic [ADDR_W-1:0]  dec_mask,
    input  xw_pkg::perm_e      dec_perm,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic [ADDR_W-1:0]  rsp_mask,
    output logic [1:0]         rsp_perm
);
    import xw_pkg::*;

    walk_st_e          st;
    logic [ADDR_W-1:0] maddr_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [ADDR_W-1:0] mask_q;
    perm_e             perm_q;

    // state and result registers of the single walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= W_IDLE;
            iova_q  <= '0;
            maddr_q <= '0;
            paddr_q <= '0;
            mask_q  <= '0;
            perm_q  <= PERM_NONE;
        end else begin
            case (st)
                W_IDLE: begin
                    if (req_valid) begin
                        iova_q <= req_iova;
                        if (!xl_en) begin
                            paddr_q <= req_iova;
                            mask_q  <= ADDR_W'(PG8_MASK);
                            perm_q  <= PERM_RW;
                            st      <= W_RESP;
                        end else if (size_bad) begin
                            paddr_q <= '0;
                            mask_q  <= '1;
                            perm_q  <= PERM_NONE;
                            st      <= W_RESP;
                        end else begin
                            maddr_q <= ADDR_W'(ent_addr);
                            st      <= W_FETCH;
                        end
                    end
                end
                W_FETCH: begin
                    if (mem_req_ready) st <= W_WAIT;
                end
                W_WAIT: begin
                    if (mem_rsp_valid) begin
                        paddr_q <= dec_paddr;
                        mask_q  <= dec_mask;
                        perm_q  <= dec_perm;
                        st      <= W_RESP;
                    end
                end
                W_RESP: begin
                    if (rsp_ready) st <= W_IDLE;
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    assign req_ready     = (st == W_IDLE);
    assign mem_req_valid = (st == W_FETCH);
    assign mem_req_addr  = maddr_q;
    assign rsp_valid     = (st == W_RESP);
    assign rsp_paddr     = paddr_q;
    assign rsp_mask      = mask_q;
    assign rsp_perm      = perm_q;

endmodule

// File: rtl/dma_xlate_walker.sv
// Top of the DMA translation table walker: register file, index
// generator, entry decoder and walk sequencer. One walk at a time,
// no entry caching. Control and base are sampled when a request is
// accepted.
module dma_xlate_walker #(
    parameter int ADDR_W = 64,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic              reg_wide,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_iova,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [ADDR_W-1:0] rsp_mask,
    output logic [1:0]        rsp_perm,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);
    import xw_pkg::*;

    logic [63:0]        ctrl_q;
    logic [63:0]        base_q;
    logic [63:0]        ent_addr;
    logic               size_bad;
    logic [ADDR_W-1:0]  iova_q;
    logic [ADDR_W-1:0]  dec_paddr;
    logic [ADDR_W-1:0]  dec_mask;
    perm_e              dec_perm;
    logic               unused_ctrl;

    assign unused_ctrl = ^ctrl_q;

    xw_regs #(.REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_wide  (reg_wide),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl_q    (ctrl_q),
        .base_q    (base_q)
    );

    xw_index #(.ADDR_W(ADDR_W)) u_index (
        .iova     (req_iova),
        .pg64     (ctrl_q[CTL_PG64]),
        .tsz      (ctrl_q[CTL_TSZ_LO +: CTL_TSZ_W]),
        .base     (base_q),
        .ent_addr (ent_addr),
        .size_bad (size_bad)
    );

    xw_entry #(.ADDR_W(ADDR_W)) u_entry (
        .lanes (mem_rsp_data),
        .iova  (iova_q),
        .paddr (dec_paddr),
        .mask  (dec_mask),
        .perm  (dec_perm)
    );

    xw_walk #(.ADDR_W(ADDR_W)) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_iova      (req_iova),
        .xl_en         (ctrl_q[CTL_EN]),
        .size_bad      (size_bad),
        .ent_addr      (ent_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .iova_q        (iova_q),
        .dec_paddr     (dec_paddr),
        .dec_mask      (dec_mask),
        .dec_perm      (dec_perm),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_mask      (rsp_mask),
        .rsp_perm      (rsp_perm)
    );

endmodule

// File: rtl/xw_checker.sv
// Protocol and result-shape properties of the walker, bound to its top.
module xw_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [ADDR_W-1:0] rsp_mask,
    input logic [1:0]        rsp_perm,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr
);
    // R4: reset clears pending response and memory read
    p_reset_idle_r4: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !mem_req_valid && req_ready));

    // R12: a stalled response keeps its value
    p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                       && $stable(rsp_mask) && $stable(rsp_perm)));

    // R12: a stalled memory read keeps its address
    p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R12: a new request is only taken with nothing in flight
    p_one_walk_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req_valid));

    // R7: a response without permission has the fault shape
    p_fault_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm == 2'b00) |-> (rsp_paddr == '0 && rsp_mask == '1));

    // R10: a granted response carries one of the two page masks
    p_page_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm != 2'b00) |->
        (rsp_mask == ADDR_W'(64'h1FFF) || rsp_mask == ADDR_W'(64'hFFFF)));

endmodule

bind dma_xlate_walker xw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_mask      (rsp_mask),
    .rsp_perm      (rsp_perm),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/dma_xlate_walker_bench.sv
`timescale 1ns/1ps
module dma_xlate_walker_bench;
    localparam int AW  = 64;
    localparam int RAW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n;
    logic           reg_valid, reg_write, reg_wide;
    logic [RAW-1:0] reg_addr;
    logic [63:0]    reg_wdata, reg_rdata;
    logic           req_valid, req_ready;
    logic [AW-1:0]  req_iova;
    logic           rsp_valid, rsp_ready;
    logic [AW-1:0]  rsp_paddr, rsp_mask;
    logic [1:0]     rsp_perm;
    logic           mem_req_valid, mem_req_ready;
    logic [AW-1:0]  mem_req_addr;
    logic           mem_rsp_valid;
    logic [63:0]    mem_rsp_data;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    int mem_lat   = 1;
    int ready_lat = 0;

    logic [63:0] m_ctrl = '0;
    logic [63:0] m_base = '0;
    logic [63:0] ent_tab [logic [63:0]];
    logic [63:0] q_pa[$], q_mk[$], q_ea[$];
    logic [1:0]  q_pm[$];
    string       q_tag[$];

    dma_xlate_walker u_dma_xlate_walker (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_wide(reg_wide),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_iova(req_iova),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_mask(rsp_mask), .rsp_perm(rsp_perm),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // table index arithmetic of R5 / R6 / R7
    function automatic logic [63:0] walk_addr(logic [63:0] iova, output bit bad);
        int code;
        int nb;
        logic [63:0] idx;
        code = int'(m_ctrl[18:16]);
        bad  = 1'b0;
        nb   = 10 + code;
        if (m_ctrl[2]) begin
            if (code > 5) begin
                bad = 1'b1;
                return 64'h0;
            end
            idx = (iova >> 16) & ((64'd1 << nb) - 64'd1);
        end else begin
            idx = (iova >> 13) & ((64'd1 << nb) - 64'd1);
        end
        return m_base + idx * 64'd8;
    endfunction

    // big-endian lane placement of R11
    function automatic logic [63:0] to_lanes(logic [63:0] e);
        logic [63:0] l;
        for (int k = 0; k < 8; k++) l[8*k +: 8] = e[63-8*k -: 8];
        return l;
    endfunction

    task automatic put_ent(logic [63:0] iova, logic [63:0] val);
        bit bad;
        logic [63:0] ea;
        ea = walk_addr(iova, bad);
        ent_tab[ea] = val;
    endtask

    task automatic predict(logic [63:0] iova, string tag);
        bit bad;
        logic [63:0] ea, ent, pa, mk;
        logic [1:0]  pm;
        pa = 64'h0; mk = '1; pm = 2'b00;
        if (!m_ctrl[0]) begin
            pa = iova; mk = 64'h1FFF; pm = 2'b11;
        end else begin
            ea = walk_addr(iova, bad);
            if (!bad) begin
                q_ea.push_back(ea);
                ent = ent_tab.exists(ea) ? ent_tab[ea] : 64'h0;
                if (ent[63]) begin
                    pm = ent[1] ? 2'b11 : 2'b01;
                    if (ent[61]) begin
                        pa = (ent & 64'h0000_01FF_FFFF_8000) | (iova & 64'hFFFF);
                        mk = 64'hFFFF;
                    end else begin
                        pa = (ent & 64'h0000_01FF_FFFF_E000) | (iova & 64'h1FFF);
                        mk = 64'h1FFF;
                    end
                end
            end
        end
        q_pa.push_back(pa); q_mk.push_back(mk); q_pm.push_back(pm); q_tag.push_back(tag);
    endtask

    task automatic reg_wr(logic [4:0] a, bit wide, logic [63:0] d);
        @(negedge clk);
        reg_valid = 1; reg_write = 1; reg_wide = wide; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
        case (a)
            5'h00: if (wide) m_ctrl = d; else m_ctrl[63:32] = d[31:0];
            5'h04: m_ctrl[31:0] = d[31:0];
            5'h08: if (wide) m_base = d; else m_base[63:32] = d[31:0];
            5'h0C: m_base[31:0] = d[31:0];
            default: ;
        endcase
    endtask

    task automatic reg_rd(logic [4:0] a, bit wide, logic [63:0] exp, string rq);
        @(negedge clk);
        reg_valid = 1; reg_write = 0; reg_wide = wide; reg_addr = a;
        #1;
        check(rq, $sformatf("read offset %h", a), reg_rdata, exp);
        reg_valid = 0;
    endtask

    task automatic xlate(logic [63:0] iova, string tag);
        predict(iova, tag);
        @(negedge clk);
        req_valid = 1; req_iova = iova;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        while (q_pa.size() != 0) @(negedge clk);
    endtask

    // memory model: checks the entry address and returns entry lanes
    initial begin
        logic [63:0] a;
        logic [63:0] e;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid && !done) begin
                a = mem_req_addr;
                if (q_ea.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7 unexpected table read: actual=%h expected=none", a);
                end else begin
                    check("R5/R6", "entry address", a, q_ea.pop_front());
                end
                repeat (ready_lat) @(negedge clk);
                mem_req_ready = 1;
                @(negedge clk);
                mem_req_ready = 0;
                repeat (mem_lat) @(negedge clk);
                e = ent_tab.exists(a) ? ent_tab[a] : 64'h0;
                mem_rsp_valid = 1; mem_rsp_data = to_lanes(e);
                @(negedge clk);
                mem_rsp_valid = 0;
            end
        end
    end

    // response comparison on every clock
    always @(negedge clk) begin
        if (rst_n && !done && rsp_valid) begin
            if (q_pa.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 response with nothing pending: actual=%h expected=none", rsp_paddr);
            end else if (rsp_ready) begin
                check(q_tag[0], "paddr", rsp_paddr, q_pa[0]);
                check(q_tag[0], "mask",  rsp_mask,  q_mk[0]);
                check(q_tag[0], "perm",  64'(rsp_perm), 64'(q_pm[0]));
                void'(q_pa.pop_front()); void'(q_mk.pop_front());
                void'(q_pm.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; reg_valid = 0; reg_write = 0; reg_wide = 0; reg_addr = '0;
        reg_wdata = '0; req_valid = 0; req_iova = '0; rsp_ready = 1;
        repeat (3) @(negedge clk);
        check("R4", "req_ready in reset", 64'(req_ready), 64'd1);
        check("R4", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check("R4", "mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1;
        reg_rd(5'h00, 1, 64'h0, "R4");
        reg_rd(5'h08, 1, 64'h0, "R4");
        xlate(64'hFEDC_BA98_7654_3211, "R4");

        // R1: halves and full register access
        reg_wr(5'h08, 1, 64'h0011_2233_4455_6678);
        reg_rd(5'h08, 1, 64'h0011_2233_4455_6678, "R1");
        reg_rd(5'h08, 0, 64'h0000_0000_0011_2233, "R1");
        reg_rd(5'h0C, 0, 64'h0000_0000_4455_6678, "R1");
        reg_wr(5'h08, 0, 64'hFFFF_FFFF_CAFE_F00D);
        reg_wr(5'h0C, 0, 64'h0000_0000_8000_0000);
        reg_rd(5'h08, 1, 64'hCAFE_F00D_8000_0000, "R1");
        reg_wr(5'h00, 0, 64'h0000_0000_1357_9BDF);
        reg_rd(5'h04, 0, 64'h0, "R1");
        reg_rd(5'h00, 1, 64'h1357_9BDF_0000_0000, "R1");

        // R2: flush and unmapped offsets
        reg_wr(5'h10, 1, '1);
        reg_wr(5'h14, 0, '1);
        reg_wr(5'h18, 1, '1);
        reg_wr(5'h01, 1, '1);
        reg_wr(5'h0A, 1, '1);
        reg_rd(5'h10, 1, 64'h0, "R2");
        reg_rd(5'h14, 0, 64'h0, "R2");
        reg_rd(5'h1C, 0, 64'h0, "R2");
        reg_rd(5'h00, 1, 64'h1357_9BDF_0000_0000, "R2");
        reg_rd(5'h08, 1, 64'hCAFE_F00D_8000_0000, "R2");

        // R3: disabled translation ignores other control bits
        reg_wr(5'h04, 0, 64'h0007_0004);
        xlate(64'h0123_4567_89AB_CDEF, "R3");

        // R5: 8K windows
        reg_wr(5'h08, 1, 64'h0000_0000_1000_0000);
        reg_wr(5'h00, 1, 64'h0000_0000_0000_0001);
        put_ent(64'hFFFF_FFFF_FFC0_2ABC, 64'hC004_0155_5555_4002);
        xlate(64'hFFFF_FFFF_FFC0_2ABC, "R5");
        xlate(64'hFFFF_FFFF_FF40_2ABC, "R5");
        reg_wr(5'h00, 1, 64'h0000_0000_0007_0001);
        put_ent(64'h0000_0000_3FFF_F123, 64'h8000_00AA_5500_2000);
        xlate(64'h0000_0000_3FFF_F123, "R9");
        reg_wr(5'h00, 1, 64'h0000_0000_0003_0001);
        put_ent(64'h0000_0000_0123_4567, 64'h8000_0001_2345_6002);
        xlate(64'h0000_0000_0123_4567, "R5");

        // R6 / R10: 64K windows with both page sizes
        reg_wr(5'h00, 1, 64'h0000_0000_0000_0005);
        put_ent(64'h0000_0000_03AB_CDEF, 64'hA000_1234_5678_9002);
        xlate(64'h0000_0000_03AB_CDEF, "R10");
        reg_wr(5'h00, 1, 64'h0000_0000_0005_0005);
        put_ent(64'h0000_0000_7FFF_1234, 64'h8000_0077_6655_4002);
        xlate(64'h0000_0000_7FFF_1234, "R6");

        // R7: codes without a 64K window
        reg_wr(5'h00, 1, 64'h0000_0000_0006_0005);
        xlate(64'h0000_0000_1234_5678, "R7");
        reg_wr(5'h00, 1, 64'h0000_0000_0007_0005);
        xlate(64'h0000_0000_0000_0000, "R7");

        // R8: invalid and missing entries
        reg_wr(5'h00, 1, 64'h0000_0000_0000_0001);
        put_ent(64'h0000_0000_0055_E000, 64'h7FFF_FFFF_FFFF_FFFF);
        xlate(64'h0000_0000_0055_E000, "R8");
        xlate(64'h0000_0000_0066_0000, "R8");

        // R11: distinct bytes expose the lane order
        put_ent(64'h0000_0000_0011_2FFF, 64'h8000_0123_4567_A002);
        xlate(64'h0000_0000_0011_2FFF, "R11");

        // R12: stalled memory and stalled consumer
        ready_lat = 3; mem_lat = 4; rsp_ready = 0;
        predict(64'h0000_0000_0011_2345, "R12");
        @(negedge clk);
        req_valid = 1; req_iova = 64'h0000_0000_0011_2345;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 40 && !rsp_valid; i++) @(negedge clk);
        check("R12", "response after stalled fetch", 64'(rsp_valid), 64'd1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R12", "response held", 64'(rsp_valid), 64'd1);
            check("R12", "busy while held", 64'(req_ready), 64'd0);
        end
        rsp_ready = 1;
        while (q_pa.size() != 0) @(negedge clk);
        @(negedge clk);
        check("R12", "ready after handshake", 64'(req_ready), 64'd1);
        ready_lat = 0; mem_lat = 1;
        check("R5/R6", "all reads issued", 64'(q_ea.size()), 64'd0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule